// File: doc/BRIEF.md
# Inbound Requester-to-Partition Authorizer

This block sits on the inbound side of a PCIe host bridge. Each request that enters carries a 16-bit requester ID, an address, a kind (DMA, MSI or error message) and the interrupt-number field of its MSI data. A table indexed by requester ID yields the partition number that owns the requester. For DMA the block also reports which of the partition's two DMA windows applies. For an MSI it finds which of two MSI address windows was hit and forms an interrupt index. It then reads that interrupt's descriptor and lets the MSI through only when the descriptor's partition equals the requester's partition.

Results leave through a one-entry registered output stage with valid/ready handshaking, one cycle after a request is accepted. Both tables are loaded through plain write ports. An MSI that is denied raises a sticky violation flag that keeps the requester ID of the first offender until it is cleared.

Top module: `req_part_auth`

## Requirements
- R1: After reset `out_valid`, `viol_flag` and `viol_rid` are 0 and `in_ready` is 1.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are high. Its result is valid from that edge on. `out_part` is the partition table entry at index `in_rid[LKUP_AW-1:0]` (the whole ID when `LKUP_AW` is 16) and `out_kind` echoes the kind. An entry written by `tbl_wr_en` on one edge is what a request accepted on a later edge sees.
- R3: Kind code 2'b00 is DMA. For DMA `out_dma_win` equals address bit 59 and `out_allow` is 1. For every other kind `out_dma_win` is 0.
- R4: Kind code 2'b01 is MSI. Window A is the top 64 KB of 32-bit space (address bits 63:16 equal 0x0000_0000_FFFF) and has base index 0. Window B is the 64 KB block whose bits 63:16 equal 0x0000_0100_0000 and has base index 1024. On a hit, `out_irq` is the low 11 bits of the data field plus the window's base. On a miss, and for all other kinds, `out_irq` is 0.
- R5: An MSI is allowed (`out_allow`=1) only if it hits a window and the descriptor at `out_irq` holds the same partition number as `out_part`. Otherwise it is denied. Descriptors are written through `desc_wr_en`.
- R6: Kind code 2'b10 (error message) and the reserved code 2'b11 go through the requester lookup only, with `out_allow`=1.
- R7: When a denied MSI result is taken (`out_valid` and `out_ready` high), `viol_flag` is set from the next edge. If the flag was clear, `viol_rid` records that request's requester ID. While the flag is set and no clear is applied, both the flag and the recorded ID hold.
- R8: `viol_clr` clears the flag on the next edge. If a denied MSI is taken in that same cycle, the flag is set instead and `viol_rid` takes the new ID.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_rid | input | 16 | Requester ID (bus/device/function) |
| in_addr | input | 64 | Request address |
| in_kind | input | 2 | 00 DMA, 01 MSI, 10 error message, 11 reserved |
| in_msi_data | input | 11 | Interrupt-number field of the MSI data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken by the consumer |
| out_kind | output | 2 | Kind of the request |
| out_part | output | 8 | Partition number from the requester lookup |
| out_dma_win | output | 1 | DMA window select |
| out_irq | output | 11 | Interrupt index |
| out_allow | output | 1 | Request is allowed (MSI check result) |
| tbl_wr_en | input | 1 | Write the requester partition table |
| tbl_wr_idx | input | 10 | Requester table index |
| tbl_wr_part | input | 8 | Partition number written |
| desc_wr_en | input | 1 | Write an interrupt descriptor |
| desc_wr_irq | input | 11 | Descriptor index |
| desc_wr_part | input | 8 | Descriptor partition number |
| viol_clr | input | 1 | Clear the violation flag |
| viol_flag | output | 1 | Sticky MSI violation flag |
| viol_rid | output | 16 | Requester ID of the first recorded violation |

## Verification
A request accepted on a rising edge has its result on the outputs from that edge on. The bench therefore checks at every falling edge that `out_valid` matches a non-empty queue of predicted results, and compares the head of the queue with the outputs in the cycle where it drives `out_ready` high. The violation flag and recorded ID change on the edge after a denied MSI is taken or a clear is driven. The bench updates its flag model only after checking the current cycle, so each comparison lines up with the one register stage in between. When backpressure is applied, the held outputs are compared one cycle later against a snapshot taken in the stalled cycle.

// File: rtl/rpa_pkg.sv
// Package: shared request-kind codes for the requester-to-partition authorizer.
// Assumes 2-bit kind codes; the reserved code is handled like an error message.
package rpa_pkg;
    typedef enum logic [1:0] {
        KIND_DMA = 2'b00,
        KIND_MSI = 2'b01,
        KIND_ERR = 2'b10,
        KIND_RSV = 2'b11
    } req_kind_e;
endpackage

// File: rtl/rpa_sync_table.sv
// Module: single-write, single-read table with a registered read port.
// Assumes the read is enabled only when a new lookup is launched, so the read
// data holds while a result waits at the output. Same-address write and read
// on one edge returns the old contents.
module rpa_sync_table #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Table update from the write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read, launched with each accepted request.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/rpa_msi_decode.sv
// Module: matches an address against the two MSI windows and forms the
// interrupt index as the low bits of (data field + window base index).
// Assumes both windows are naturally aligned blocks of 2**WIN_LOG2 bytes;
// window A wins if the two overlap.
module rpa_msi_decode #(
    parameter int                ADDR_W     = 64,
    parameter int                IRQ_W      = 11,
    parameter int                WIN_LOG2   = 16,
    parameter logic [ADDR_W-1:0] HI_BASE    = 64'h0000_0100_0000_0000,
    parameter int                IRQ_BASE_A = 0,
    parameter int                IRQ_BASE_B = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IRQ_W-1:0]  data,
    output logic              hit,
    output logic [IRQ_W-1:0]  irq_idx
);
    localparam int                NWIN     = 2;
    localparam logic [ADDR_W-1:0] LOW_TOP  = ADDR_W'(65'h1_0000_0000 - (65'd1 << WIN_LOG2));
    localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'((65'd1 << WIN_LOG2) - 65'd1);
    localparam logic [ADDR_W-1:0] WBASE [NWIN] = '{LOW_TOP, HI_BASE};
    localparam logic [IRQ_W-1:0]  IBASE [NWIN] = '{IRQ_W'(IRQ_BASE_A), IRQ_W'(IRQ_BASE_B)};

    logic [NWIN-1:0] win_hit;
    logic [IRQ_W-1:0] win_idx [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        // Per-window address match and index sum.
        always_comb begin
            win_hit[w] = ((addr ^ WBASE[w]) & WIN_MASK) == '0;
            win_idx[w] = data + IBASE[w];
        end
    end

    // Priority select between the windows; no hit gives index 0.
    always_comb begin
        hit     = |win_hit;
        irq_idx = '0;
        if (win_hit[0]) begin
            irq_idx = win_idx[0];
        end else if (win_hit[1]) begin
            irq_idx = win_idx[1];
        end
    end
endmodule

// File: rtl/rpa_violation_log.sv
// Module: sticky record of denied MSIs. Keeps the requester ID of the first
// offender until cleared; a new offence in the clear cycle wins over the clear.
module rpa_violation_log #(
    parameter int RID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             log_en,
    input  logic [RID_W-1:0] log_rid,
    input  logic             clr,
    output logic             flag,
    output logic [RID_W-1:0] rid
);
    // Set on an offence when empty or being cleared, otherwise clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            rid  <= '0;
        end else if (log_en && (!flag || clr)) begin
            flag <= 1'b1;
            rid  <= log_rid;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/req_part_auth.sv
// Module: inbound requester-to-partition authorizer (top).
// Looks up the requester's partition, selects the DMA window, decodes MSI
// windows into an interrupt index and authorizes MSIs against the interrupt
// descriptor's partition. One-entry registered output with valid/ready.
// Assumes tables are loaded before traffic that depends on them.
module req_part_auth
    import rpa_pkg::*;
#(
    parameter int                RID_W       = 16,
    parameter int                LKUP_AW     = 10,
    parameter int                PART_W      = 8,
    parameter int                ADDR_W      = 64,
    parameter int                IRQ_W       = 11,
    parameter int                DMA_SEL_BIT = 59,
    parameter int                MSI_WIN_LOG2 = 16,
    parameter logic [ADDR_W-1:0] MSI_HI_BASE = 64'h0000_0100_0000_0000,
    parameter int                IRQ_BASE_A  = 0,
    parameter int                IRQ_BASE_B  = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [RID_W-1:0]   in_rid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [1:0]         in_kind,
    input  logic [IRQ_W-1:0]   in_msi_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_kind,
    output logic [PART_W-1:0]  out_part,
    output logic               out_dma_win,
    output logic [IRQ_W-1:0]   out_irq,
    output logic               out_allow,
    input  logic               tbl_wr_en,
    input  logic [LKUP_AW-1:0] tbl_wr_idx,
    input  logic [PART_W-1:0]  tbl_wr_part,
    input  logic               desc_wr_en,
    input  logic [IRQ_W-1:0]   desc_wr_irq,
    input  logic [PART_W-1:0]  desc_wr_part,
    input  logic               viol_clr,
    output logic               viol_flag,
    output logic [RID_W-1:0]   viol_rid
);
    localparam int N_DESC_AW = IRQ_W;

    logic              accept;
    logic              vld_q;
    req_kind_e         kind_in;
    req_kind_e         kind_q;
    logic              win_q;
    logic              hit_q;
    logic [IRQ_W-1:0]  irq_q;
    logic [RID_W-1:0]  rid_q;
    logic              dec_hit;
    logic [IRQ_W-1:0]  dec_irq;
    logic [PART_W-1:0] rtt_part;
    logic [PART_W-1:0] desc_part;
    logic              denied_taken;

    // Handshake: room when empty or when the held result is being taken.
    always_comb begin
        kind_in  = req_kind_e'(in_kind);
        in_ready = !vld_q || out_ready;
        accept   = in_valid && in_ready;
    end

    rpa_msi_decode #(
        .ADDR_W     (ADDR_W),
        .IRQ_W      (IRQ_W),
        .WIN_LOG2   (MSI_WIN_LOG2),
        .HI_BASE    (MSI_HI_BASE),
        .IRQ_BASE_A (IRQ_BASE_A),
        .IRQ_BASE_B (IRQ_BASE_B)
    ) u_msi_dec (
        .addr    (in_addr),
        .data    (in_msi_data),
        .hit     (dec_hit),
        .irq_idx (dec_irq)
    );

    rpa_sync_table #(
        .AW (LKUP_AW),
        .DW (PART_W)
    ) u_rid_table (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_idx),
        .wr_data (tbl_wr_part),
        .rd_en   (accept),
        .rd_addr (in_rid[LKUP_AW-1:0]),
        .rd_data (rtt_part)
    );

    rpa_sync_table #(
        .AW (N_DESC_AW),
        .DW (PART_W)
    ) u_desc_table (
        .clk     (clk),
        .wr_en   (desc_wr_en),
        .wr_addr (desc_wr_irq),
        .wr_data (desc_wr_part),
        .rd_en   (accept),
        .rd_addr (dec_irq),
        .rd_data (desc_part)
    );

    // Output valid: set on accept, dropped once the consumer takes the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (accept) begin
            vld_q <= 1'b1;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    // Request attributes captured alongside the table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_DMA;
            win_q  <= 1'b0;
            hit_q  <= 1'b0;
            irq_q  <= '0;
            rid_q  <= '0;
        end else if (accept) begin
            kind_q <= kind_in;
            win_q  <= (kind_in == KIND_DMA) && in_addr[DMA_SEL_BIT];
            hit_q  <= (kind_in == KIND_MSI) && dec_hit;
            irq_q  <= ((kind_in == KIND_MSI) && dec_hit) ? dec_irq : '0;
            rid_q  <= in_rid;
        end
    end

    // Result formation and MSI authorization against the descriptor.
    always_comb begin
        out_valid   = vld_q;
        out_kind    = kind_q;
        out_part    = rtt_part;
        out_dma_win = win_q;
        out_irq     = irq_q;
        if (kind_q == KIND_MSI) begin
            out_allow = hit_q && (desc_part == rtt_part);
        end else begin
            out_allow = 1'b1;
        end
        denied_taken = vld_q && out_ready && (kind_q == KIND_MSI) && !out_allow;
    end

    rpa_violation_log #(
        .RID_W (RID_W)
    ) u_viol (
        .clk     (clk),
        .rst_n   (rst_n),
        .log_en  (denied_taken),
        .log_rid (rid_q),
        .clr     (viol_clr),
        .flag    (viol_flag),
        .rid     (viol_rid)
    );
endmodule

// File: rtl/rpa_auth_chk.sv
// Module: assertion checker for req_part_auth, attached with bind below.
// Assumes the kind codes of rpa_pkg.
module rpa_auth_chk #(
    parameter int RID_W  = 16,
    parameter int PART_W = 8,
    parameter int IRQ_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_kind,
    input logic [PART_W-1:0] out_part,
    input logic              out_dma_win,
    input logic [IRQ_W-1:0]  out_irq,
    input logic              out_allow,
    input logic              viol_clr,
    input logic              viol_flag,
    input logic [RID_W-1:0]  viol_rid
);
    logic deny_take;
    assign deny_take = out_valid && out_ready && (out_kind == 2'b01) && !out_allow;

    // R9
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_part) && $stable(out_kind)
                                       && $stable(out_irq) && $stable(out_allow)
                                       && $stable(out_dma_win)));

    // R3
    dma_win_only_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'b00) |-> !out_dma_win);

    // R6
    err_always_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind[1]) |-> out_allow);

    // R7
    deny_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny_take |=> viol_flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !viol_clr) |=> (viol_flag && $stable(viol_rid)));

    // R8
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_clr && !deny_take) |=> !viol_flag);
endmodule

bind req_part_auth rpa_auth_chk #(
    .RID_W  (RID_W),
    .PART_W (PART_W),
    .IRQ_W  (IRQ_W)
) u_auth_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_kind    (out_kind),
    .out_part    (out_part),
    .out_dma_win (out_dma_win),
    .out_irq     (out_irq),
    .out_allow   (out_allow),
    .viol_clr    (viol_clr),
    .viol_flag   (viol_flag),
    .viol_rid    (viol_rid)
);

// File: tb/req_part_auth_tb_top.sv
`timescale 1ns/1ps
// Bench: seeded random plus directed traffic, predicted from bench-side table
// models and compared at falling edges.
module req_part_auth_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_rid = '0;
    logic [63:0] in_addr = '0;
    logic [1:0]  in_kind = '0;
    logic [10:0] in_msi_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_kind;
    logic [7:0]  out_part;
    logic        out_dma_win;
    logic [10:0] out_irq;
    logic        out_allow;
    logic        tbl_wr_en = 1'b0;
    logic [9:0]  tbl_wr_idx = '0;
    logic [7:0]  tbl_wr_part = '0;
    logic        desc_wr_en = 1'b0;
    logic [10:0] desc_wr_irq = '0;
    logic [7:0]  desc_wr_part = '0;
    logic        viol_clr = 1'b0;
    logic        viol_flag;
    logic [15:0] viol_rid;

    always #2.5 clk = ~clk;

    req_part_auth dut_i (.*);

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  part;
        logic        win;
        logic [10:0] irq;
        logic        allow;
        logic [15:0] rid;
    } exp_t;

    logic [7:0] rtt_m  [1024];
    logic [7:0] desc_m [2048];
    exp_t       expq [$];
    int         errors = 0;
    int         checks = 0;
    logic       exp_flag = 1'b0;
    logic [15:0] exp_vrid = '0;
    logic       hold_pend = 1'b0;
    exp_t       snap;
    logic [31:0] seed_sink;

    localparam logic [63:0] WIN_A = 64'h0000_0000_FFFF_0000;
    localparam logic [63:0] WIN_B = 64'h0000_0100_0000_0000;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic exp_t predict(input logic [15:0] rid, input logic [63:0] addr,
                                     input logic [1:0] kind, input logic [10:0] data);
        exp_t e;
        logic hit;
        e.kind  = kind;
        e.rid   = rid;
        e.part  = rtt_m[rid[9:0]];
        e.win   = (kind == 2'b00) ? addr[59] : 1'b0;
        e.irq   = '0;
        e.allow = 1'b1;
        if (kind == 2'b01) begin
            hit = 1'b1;
            if (addr[63:16] == WIN_A[63:16])      e.irq = data;
            else if (addr[63:16] == WIN_B[63:16]) e.irq = data + 11'd1024;
            else                                  hit = 1'b0;
            e.allow = hit && (desc_m[e.irq] == e.part);
        end
        return e;
    endfunction

    // One cycle: check state, drive inputs, then book the handshakes of this cycle.
    task automatic cycle(input logic v, input logic [15:0] rid, input logic [63:0] addr,
                         input logic [1:0] kind, input logic [10:0] data,
                         input logic rdy, input logic clr);
        exp_t h;
        logic ev;
        logic [15:0] ev_rid;
        @(negedge clk);
        chk(viol_flag == exp_flag, "R7 flag", viol_flag, exp_flag);
        chk(viol_rid == exp_vrid, "R7 recorded rid", viol_rid, exp_vrid);
        chk(out_valid == (expq.size() != 0), "R2 out_valid timing", out_valid, expq.size() != 0);
        if (hold_pend) begin
            chk(out_valid && {out_kind, out_part, out_dma_win, out_irq, out_allow}
                == {snap.kind, snap.part, snap.win, snap.irq, snap.allow},
                "R9 held result", {out_kind, out_part, out_irq}, {snap.kind, snap.part, snap.irq});
        end
        in_valid = v; in_rid = rid; in_addr = addr; in_kind = kind; in_msi_data = data;
        out_ready = rdy; viol_clr = clr;
        #1;
        ev = 1'b0; ev_rid = '0;
        hold_pend = 1'b0;
        if (out_valid && !out_ready) begin
            chk(!in_ready, "R9 in_ready low while stalled", in_ready, 0);
            snap = '{kind: out_kind, part: out_part, win: out_dma_win, irq: out_irq,
                     allow: out_allow, rid: '0};
            hold_pend = 1'b1;
        end
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2 unexpected result", 1, 0);
            end else begin
                h = expq.pop_front();
                chk(out_kind == h.kind, "R2 kind echo", out_kind, h.kind);
                chk(out_part == h.part, "R2 partition", out_part, h.part);
                chk(out_dma_win == h.win, "R3 dma window", out_dma_win, h.win);
                chk(out_irq == h.irq, "R4 irq index", out_irq, h.irq);
                if (h.kind == 2'b01) chk(out_allow == h.allow, "R5 msi allow", out_allow, h.allow);
                else                 chk(out_allow == h.allow, "R6 non-msi allow", out_allow, h.allow);
                if (h.kind == 2'b01 && !h.allow) begin
                    ev = 1'b1; ev_rid = h.rid;
                end
            end
        end
        if (in_valid && in_ready) expq.push_back(predict(rid, addr, kind, data));
        if (ev && (!exp_flag || clr)) begin
            exp_flag = 1'b1; exp_vrid = ev_rid;
        end else if (clr) begin
            exp_flag = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, '0, '0, 2'b00, '0, 1'b1, 1'b0);
    endtask

    task automatic write_tables(input logic we_r, input logic [9:0] ri, input logic [7:0] rv,
                                input logic we_d, input logic [10:0] di, input logic [7:0] dv);
        @(negedge clk);
        tbl_wr_en = we_r; tbl_wr_idx = ri; tbl_wr_part = rv;
        desc_wr_en = we_d; desc_wr_irq = di; desc_wr_part = dv;
        if (we_r) rtt_m[ri] = rv;
        if (we_d) desc_m[di] = dv;
        @(negedge clk);
        tbl_wr_en = 1'b0; desc_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state while reset is held
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(viol_flag == 1'b0, "R1 viol_flag", viol_flag, 0);
        chk(viol_rid == '0, "R1 viol_rid", viol_rid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Load both tables: partitions drawn from a small set so matches occur.
        for (int i = 0; i < 2048; i++) begin
            @(negedge clk);
            tbl_wr_en = (i < 1024); tbl_wr_idx = 10'(i); tbl_wr_part = 8'($urandom % 4);
            desc_wr_en = 1'b1; desc_wr_irq = 11'(i); desc_wr_part = 8'($urandom % 4);
            if (i < 1024) rtt_m[i] = tbl_wr_part;
            desc_m[i] = desc_wr_part;
        end
        @(negedge clk);
        tbl_wr_en = 1'b0; desc_wr_en = 1'b0;

        // R3 DMA with bit 59 set and clear
        cycle(1'b1, 16'h0105, 64'h0800_0000_0000_1000, 2'b00, '0, 1'b1, 1'b0);
        cycle(1'b1, 16'h0106, 64'h0000_0000_0000_2000, 2'b00, '0, 1'b1, 1'b0);
        // R6 error message and reserved kind
        cycle(1'b1, 16'h0207, 64'h0800_0000_0000_0000, 2'b10, 11'h3, 1'b1, 1'b0);
        cycle(1'b1, 16'h0208, WIN_A, 2'b11, 11'h5, 1'b1, 1'b0);
        idle(2);

        // R2/R5 write-then-use: rid 0x0321 -> partition 9, descriptor 0x10 -> 9 (window A match)
        write_tables(1'b1, 10'h321, 8'd9, 1'b1, 11'h010, 8'd9);
        cycle(1'b1, 16'h0321, WIN_A | 64'h40, 2'b01, 11'h010, 1'b1, 1'b0);
        idle(2);
        // R4 window B with wrap: data 0x7FF + 1024 -> index 1023; descriptor mismatch -> deny, R7 flag
        write_tables(1'b0, '0, '0, 1'b1, 11'h3FF, 8'd77);
        cycle(1'b1, 16'h0321, WIN_B | 64'h4, 2'b01, 11'h7FF, 1'b1, 1'b0);
        idle(2);
        // R7 second denial (miss outside windows) keeps the first rid
        cycle(1'b1, 16'h0ABC, 64'h0000_0000_FFFE_0000, 2'b01, 11'h1, 1'b1, 1'b0);
        idle(2);
        // R8 plain clear
        cycle(1'b0, '0, '0, 2'b00, '0, 1'b1, 1'b1);
        idle(2);
        // R8 clear in the same cycle a denied MSI is taken
        cycle(1'b1, 16'h0BEE, 64'h0000_0000_1234_0000, 2'b01, 11'h2, 1'b1, 1'b0);
        cycle(1'b0, '0, '0, 2'b00, '0, 1'b1, 1'b1);
        idle(2);
        cycle(1'b0, '0, '0, 2'b00, '0, 1'b1, 1'b1);
        // R9 backpressure for three cycles
        cycle(1'b1, 16'h0055, WIN_A, 2'b01, 11'h20, 1'b0, 1'b0);
        cycle(1'b1, 16'h0056, 64'h0800_0000_0000_0000, 2'b00, '0, 1'b0, 1'b0);
        cycle(1'b1, 16'h0056, 64'h0800_0000_0000_0000, 2'b00, '0, 1'b0, 1'b0);
        cycle(1'b1, 16'h0056, 64'h0800_0000_0000_0000, 2'b00, '0, 1'b1, 1'b0);
        idle(3);

        // Constrained random traffic with random backpressure and rare clears
        for (int n = 0; n < 4000; n++) begin
            logic [1:0]  k;
            logic [63:0] a;
            logic [31:0] sel;
            k = 2'($urandom % 4);
            sel = $urandom % 3;
            a = {$urandom, $urandom};
            if (k == 2'b01) begin
                if (sel == 0)      a = WIN_A | 64'($urandom % 65536);
                else if (sel == 1) a = WIN_B | 64'($urandom % 65536);
            end
            cycle(($urandom % 4) != 0, 16'($urandom), a, k, 11'($urandom),
                  ($urandom % 4) != 0, ($urandom % 50) == 0);
        end
        idle(4);
        chk(expq.size() == 0, "R2 queue drained", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule